// File: doc/BRIEF.md
# Dual-Port Memory with Same-Word Collision Reporting

A 256-word by 16-bit storage block with two fully independent access ports, A and B, that share one clock. In any cycle each port may read one word, write one word or stay idle. Reads and writes both land in a registered output. A write reflects the freshly stored word on the writing port's own output, so a caller sees the stored value without a second access. A port that is idle leaves its output untouched. Each port also has an output-clear input that zeroes only that port's output register.

Because both ports reach the same array in the same cycle, the block defines one rule for a collision: both ports address the same word and at least one of them writes. Data that such a cycle makes meaningless is replaced by the fixed poison word 16'hDEAD, so it is never silently wrong. A per-port flag, registered and valid in the same cycle as the data, tells the caller which output is poisoned.

Top module: `tdp_ram`

## Requirements
- R1: With enable=1 and write-enable=0 a port reads; one cycle after the sampling edge its output equals the word stored at its address.
- R2: With enable=1 and write-enable=1 a port stores its data input at its address, and one cycle after the edge its output equals that data input (write-first).
- R3: With enable=0 a port neither reads nor writes (write-enable is ignored and memory keeps its contents), and its output keeps its previous value.
- R4: A write on one port leaves the other port's output unchanged; a later read by the other port returns the newly written word.
- R5: Both ports reading the same word in the same cycle both return that word and raise no collision flag.
- R6: When both ports write the same word in one cycle, the stored word becomes 16'hDEAD, both outputs show 16'hDEAD and both collision flags rise.
- R7: When one port writes a word that the other port reads in the same cycle, the write is stored, the writing port outputs the written data with its flag low, and the reading port outputs 16'hDEAD with its flag high.
- R8: Accesses (reads or writes) to different addresses never interact and never raise a flag.
- R9: While rst_n is low at a clock edge both outputs and both flags become zero; after release an output stays zero until its port is enabled.
- R10: A high output-clear input zeroes that port's output on the edge, overriding read or write data; a write issued with it still updates memory, and the other port is unaffected.
- R11: Each collision flag is registered, aligned with the data output of the same access, and high for exactly the one cycle that follows a colliding access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of outputs and flags |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_oclr | input | 1 | Port A output clear, active high |
| a_addr | input | 8 | Port A word address |
| a_din | input | 16 | Port A write data |
| a_dout | output | 16 | Port A registered output |
| a_col | output | 1 | Port A collision flag |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_oclr | input | 1 | Port B output clear, active high |
| b_addr | input | 8 | Port B word address |
| b_din | input | 16 | Port B write data |
| b_dout | output | 16 | Port B registered output |
| b_col | output | 1 | Port B collision flag |

## Verification
Properties watch every cycle for the output relations that need no knowledge of stored contents: an idle port holding its output, write-first echo of the data input, the poison word and flag pattern after each kind of same-word clash, flags staying low for distinct addresses or twin reads, and the output clear. What lies in the array can only be shown by the directed scenarios, which write known words and read them back: that a read returns the right word, that a disabled write changes nothing, that a clashing double write leaves the poison word behind, and that a write under output clear still lands in memory.

// File: rtl/tdp_pkg.sv
// Shared types for the dual-port memory.
// Assumes: enable gates every access; write-enable only counts when enabled.
package tdp_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    // Map the raw enable pair of a port to its access kind.
    function automatic acc_e decode_acc(input logic en, input logic we);
        if (!en)
            return ACC_IDLE;
        else if (we)
            return ACC_WRITE;
        else
            return ACC_READ;
    endfunction

endpackage

// File: rtl/tdp_collide.sv
// Same-word clash detector for two ports.
// Assumes: a clash needs both ports active on one address with at least one
// writing. hit_x means port x must output poison; ww means both write.
module tdp_collide
    import tdp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  acc_e              acc_a,
    input  acc_e              acc_b,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              hit_a,
    output logic              hit_b,
    output logic              ww
);

    logic same_word;

    // Both ports active on one word.
    always_comb begin
        same_word = (acc_a != ACC_IDLE) && (acc_b != ACC_IDLE) && (addr_a == addr_b);
    end

    // A port is poisoned when the other side writes its word.
    always_comb begin
        hit_a = same_word && (acc_b == ACC_WRITE);
        hit_b = same_word && (acc_a == ACC_WRITE);
        ww    = same_word && (acc_a == ACC_WRITE) && (acc_b == ACC_WRITE);
    end

endmodule

// File: rtl/tdp_store.sv
// Storage array with two write ports and two combinational read taps.
// Assumes: the caller flags same-word double writes through ww; that word
// then receives the poison value. Contents are not reset.
module tdp_store #(
    parameter int              ADDR_W = 8,
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] POISON = '0
) (
    input  logic              clk,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic              ww,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] din_a,
    input  logic [DATA_W-1:0] din_b,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit this cycle's writes; a double write to one word stores poison.
    always_ff @(posedge clk) begin
        if (ww) begin
            mem[addr_a] <= POISON;
        end else begin
            if (wr_a)
                mem[addr_a] <= din_a;
            if (wr_b)
                mem[addr_b] <= din_b;
        end
    end

    // Pre-edge contents seen by each port.
    always_comb begin
        rd_a = mem[addr_a];
        rd_b = mem[addr_b];
    end

endmodule

// File: rtl/tdp_port_reg.sv
// Output register and collision flag of one port.
// Assumes: rdata is the pre-edge word at the port's address; hit marks a
// clash that poisons this port. Output clear beats data, reset beats all.
module tdp_port_reg
    import tdp_pkg::*;
#(
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] POISON = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              acc,
    input  logic              oclr,
    input  logic              hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dout,
    output logic              col
);

    // Register the flag for one cycle, aligned with the data it qualifies.
    always_ff @(posedge clk) begin
        if (!rst_n)
            col <= 1'b0;
        else
            col <= hit;
    end

    // Load read data, echo write data, poison on clash, hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (oclr) begin
            dout <= '0;
        end else begin
            case (acc)
                ACC_READ:  dout <= hit ? POISON : rdata;
                ACC_WRITE: dout <= hit ? POISON : wdata;
                default:   dout <= dout;
            endcase
        end
    end

endmodule

// File: rtl/tdp_ram.sv
// Two-port memory on one clock with per-port collision flags.
// Assumes: both ports share clk; a same-word access with a writer is a
// clash, resolved with the POISON word and reported one cycle later.
module tdp_ram
    import tdp_pkg::*;
#(
    parameter int              ADDR_W = 8,
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] POISON = 16'hDEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic              a_oclr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_col,
    input  logic              b_en,
    input  logic              b_we,
    input  logic              b_oclr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_din,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_col
);

    localparam int PORTS = 2;

    acc_e              acc   [PORTS];
    logic              oclr  [PORTS];
    logic              hit   [PORTS];
    logic              col   [PORTS];
    logic [DATA_W-1:0] wdat  [PORTS];
    logic [DATA_W-1:0] rdat  [PORTS];
    logic [DATA_W-1:0] dout  [PORTS];
    logic              ww;

    // Gather port inputs into per-port arrays.
    always_comb begin
        acc[0]  = decode_acc(a_en, a_we);
        acc[1]  = decode_acc(b_en, b_we);
        oclr[0] = a_oclr;
        oclr[1] = b_oclr;
        wdat[0] = a_din;
        wdat[1] = b_din;
    end

    tdp_collide #(.ADDR_W(ADDR_W)) u_collide (
        .acc_a  (acc[0]),
        .acc_b  (acc[1]),
        .addr_a (a_addr),
        .addr_b (b_addr),
        .hit_a  (hit[0]),
        .hit_b  (hit[1]),
        .ww     (ww)
    );

    tdp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POISON(POISON)) u_store (
        .clk    (clk),
        .wr_a   (acc[0] == ACC_WRITE),
        .wr_b   (acc[1] == ACC_WRITE),
        .ww     (ww),
        .addr_a (a_addr),
        .addr_b (b_addr),
        .din_a  (a_din),
        .din_b  (b_din),
        .rd_a   (rdat[0]),
        .rd_b   (rdat[1])
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        tdp_port_reg #(.DATA_W(DATA_W), .POISON(POISON)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .acc   (acc[p]),
            .oclr  (oclr[p]),
            .hit   (hit[p]),
            .wdata (wdat[p]),
            .rdata (rdat[p]),
            .dout  (dout[p]),
            .col   (col[p])
        );
    end

    // Drive the flat output ports.
    always_comb begin
        a_dout = dout[0];
        b_dout = dout[1];
        a_col  = col[0];
        b_col  = col[1];
    end

endmodule

// File: rtl/tdp_ram_chk.sv
// Cycle-level properties of tdp_ram, bound to every instance.
// Assumes: only top-level ports are observed.
module tdp_ram_chk #(
    parameter int              ADDR_W = 8,
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] POISON = 16'hDEAD
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_en,
    input logic              a_we,
    input logic              a_oclr,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_din,
    input logic [DATA_W-1:0] a_dout,
    input logic              a_col,
    input logic              b_en,
    input logic              b_we,
    input logic              b_oclr,
    input logic [ADDR_W-1:0] b_addr,
    input logic [DATA_W-1:0] b_din,
    input logic [DATA_W-1:0] b_dout,
    input logic              b_col
);

    logic same;
    assign same = a_en && b_en && (a_addr == b_addr);

    AST_A_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_en && !a_oclr) |=> $stable(a_dout)); // R3
    AST_B_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_en && !b_oclr) |=> $stable(b_dout)); // R3
    AST_A_WRITE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && !a_oclr && !(same && b_we)) |=> (a_dout == $past(a_din))); // R2
    AST_B_WRITE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && b_we && !b_oclr && !(same && a_we)) |=> (b_dout == $past(b_din))); // R2
    AST_TWIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (same && a_we && b_we && !a_oclr && !b_oclr) |=> (a_col && b_col && a_dout == POISON && b_dout == POISON)); // R6
    AST_A_READ_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (same && !a_we && b_we && !a_oclr) |=> (a_col && !b_col && a_dout == POISON)); // R7
    AST_B_READ_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (same && a_we && !b_we && !b_oclr) |=> (b_col && !a_col && b_dout == POISON)); // R7
    AST_TWIN_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (same && !a_we && !b_we) |=> (!a_col && !b_col)); // R5
    AST_NO_CLASH_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !same |=> (!a_col && !b_col)); // R8
    AST_A_OCLR: assert property (@(posedge clk) disable iff (!rst_n)
        a_oclr |=> (a_dout == '0)); // R10
    AST_B_OCLR: assert property (@(posedge clk) disable iff (!rst_n)
        b_oclr |=> (b_dout == '0)); // R10

endmodule

bind tdp_ram tdp_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POISON(POISON)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_oclr(a_oclr), .a_addr(a_addr), .a_din(a_din),
    .a_dout(a_dout), .a_col(a_col),
    .b_en(b_en), .b_we(b_we), .b_oclr(b_oclr), .b_addr(b_addr), .b_din(b_din),
    .b_dout(b_dout), .b_col(b_col)
);

// File: tb/test_tdp_ram.sv
// Directed bench for tdp_ram: one task per scenario, each checking itself.
module test_tdp_ram;

    localparam logic [15:0] BAD = 16'hDEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_en = 0, a_we = 0, a_oclr = 0;
    logic        b_en = 0, b_we = 0, b_oclr = 0;
    logic [7:0]  a_addr = '0, b_addr = '0;
    logic [15:0] a_din = '0, b_din = '0;
    logic [15:0] a_dout, b_dout;
    logic        a_col, b_col;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tdp_ram i_tdp_ram (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_oclr(a_oclr), .a_addr(a_addr), .a_din(a_din),
        .a_dout(a_dout), .a_col(a_col),
        .b_en(b_en), .b_we(b_we), .b_oclr(b_oclr), .b_addr(b_addr), .b_din(b_din),
        .b_dout(b_dout), .b_col(b_col)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drv_a(input logic en, input logic we, input logic [7:0] ad, input logic [15:0] d);
        a_en = en; a_we = we; a_addr = ad; a_din = d;
    endtask

    task automatic drv_b(input logic en, input logic we, input logic [7:0] ad, input logic [15:0] d);
        b_en = en; b_we = we; b_addr = ad; b_din = d;
    endtask

    task automatic idle();
        drv_a(0, 0, 8'h00, 16'h0);
        drv_b(0, 0, 8'h00, 16'h0);
        a_oclr = 0; b_oclr = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; idle();
        tick(); tick();
        chk("R9 a_dout in reset", a_dout, 16'h0);
        chk("R9 b_dout in reset", b_dout, 16'h0);
        chk("R9 flags in reset", {14'h0, a_col, b_col}, 16'h0);
        rst_n = 1;
        tick(); tick();
        chk("R9 a_dout idle after release", a_dout, 16'h0);
        chk("R9 b_dout idle after release", b_dout, 16'h0);
    endtask

    task automatic t_write_read();
        drv_a(1, 1, 8'h10, 16'h1234);
        tick();
        chk("R2 a write echo", a_dout, 16'h1234);
        chk("R4 b_dout untouched by A write", b_dout, 16'h0);
        drv_a(0, 0, 8'h00, 16'h0);
        drv_b(1, 0, 8'h10, 16'h0);
        tick();
        chk("R4 b reads A's word", b_dout, 16'h1234);
        chk("R1 b read flag low", {15'h0, b_col}, 16'h0);
        drv_b(1, 1, 8'hFF, 16'hABCD);
        tick();
        chk("R3 a idle holds", a_dout, 16'h1234);
        chk("R2 b write top address", b_dout, 16'hABCD);
        drv_b(0, 0, 8'h00, 16'h0);
        drv_a(1, 0, 8'hFF, 16'h0);
        tick();
        chk("R1 a read top address", a_dout, 16'hABCD);
        drv_a(1, 1, 8'h00, 16'h0F0F);
        tick();
        drv_a(1, 0, 8'h00, 16'h0);
        tick();
        chk("R1 a read address zero", a_dout, 16'h0F0F);
        idle();
    endtask

    task automatic t_disabled();
        drv_a(0, 1, 8'h10, 16'h5555);
        tick();
        chk("R3 disabled write holds output", a_dout, 16'h0F0F);
        drv_a(1, 0, 8'h10, 16'h0);
        tick();
        chk("R3 disabled write left memory", a_dout, 16'h1234);
        idle();
    endtask

    task automatic t_twin_read();
        drv_a(1, 0, 8'hFF, 16'h0);
        drv_b(1, 0, 8'hFF, 16'h0);
        tick();
        chk("R5 a twin read", a_dout, 16'hABCD);
        chk("R5 b twin read", b_dout, 16'hABCD);
        chk("R5 no flags", {14'h0, a_col, b_col}, 16'h0);
        idle();
    endtask

    task automatic t_write_read_clash();
        drv_a(1, 1, 8'h20, 16'h7777);
        drv_b(1, 0, 8'h20, 16'h0);
        tick();
        chk("R7 writer echo", a_dout, 16'h7777);
        chk("R7 reader poison", b_dout, BAD);
        chk("R7 flags A0 B1", {14'h0, a_col, b_col}, 16'h0001);
        idle();
        tick();
        chk("R11 flags drop next cycle", {14'h0, a_col, b_col}, 16'h0);
        chk("R11 reader output held", b_dout, BAD);
        drv_b(1, 0, 8'h20, 16'h0);
        tick();
        chk("R7 write was stored", b_dout, 16'h7777);
        drv_b(1, 1, 8'h21, 16'h1111);
        drv_a(1, 0, 8'h21, 16'h0);
        tick();
        chk("R7 A reader poison", a_dout, BAD);
        chk("R7 B writer echo", b_dout, 16'h1111);
        chk("R7 flags A1 B0", {14'h0, a_col, b_col}, 16'h0002);
        idle();
    endtask

    task automatic t_twin_write();
        drv_a(1, 1, 8'h30, 16'h0001);
        drv_b(1, 1, 8'h30, 16'h0002);
        tick();
        chk("R6 a poison", a_dout, BAD);
        chk("R6 b poison", b_dout, BAD);
        chk("R6 both flags", {14'h0, a_col, b_col}, 16'h0003);
        idle();
        drv_a(1, 0, 8'h30, 16'h0);
        tick();
        chk("R6 stored word poisoned", a_dout, BAD);
        chk("R11 flags one cycle", {14'h0, a_col, b_col}, 16'h0);
        idle();
    endtask

    task automatic t_distinct();
        drv_a(1, 1, 8'h40, 16'h4040);
        drv_b(1, 1, 8'h41, 16'h4141);
        tick();
        chk("R8 a own write", a_dout, 16'h4040);
        chk("R8 b own write", b_dout, 16'h4141);
        chk("R8 no flags on writes", {14'h0, a_col, b_col}, 16'h0);
        drv_a(1, 0, 8'h41, 16'h0);
        drv_b(1, 1, 8'h40, 16'hBEEF);
        tick();
        chk("R8 a reads B word", a_dout, 16'h4141);
        chk("R8 no flags mixed", {14'h0, a_col, b_col}, 16'h0);
        idle();
    endtask

    task automatic t_oclr();
        drv_a(1, 0, 8'h10, 16'h0);
        a_oclr = 1;
        tick();
        chk("R10 clear beats read", a_dout, 16'h0);
        chk("R10 b unaffected", b_dout, 16'hBEEF);
        drv_a(1, 1, 8'h50, 16'h5050);
        tick();
        chk("R10 clear beats write echo", a_dout, 16'h0);
        a_oclr = 0;
        drv_a(1, 0, 8'h50, 16'h0);
        tick();
        chk("R10 write under clear stored", a_dout, 16'h5050);
        idle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_write_read();
        t_disabled();
        t_twin_read();
        t_write_read_clash();
        t_twin_write();
        t_distinct();
        t_oclr();
        tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule